// File: doc/BRIEF.md
# Instruction Field Splitter

This block sits behind an instruction fetch queue and cuts a stream of instruction bytes for a small CISC-style subset into separate instructions, one byte per cycle. While it consumes the bytes of one instruction it tracks the prefixes, the opcode (plain, or behind the 0Fh escape byte), the addressing byte, an optional scale-index-base byte, the displacement and the immediate. When the last byte of an instruction has been taken it presents a descriptor. The descriptor holds the byte length, the opcode, an escape flag, the addressing fields widened by the extension prefix, an operand-size code and an error flag.

The control is one state machine with seven states. PREFIX takes prefixes and the first opcode byte. ESCAPE takes the opcode that follows 0Fh. ADDR takes the addressing byte. SIB takes the scale-index-base byte. DISP counts displacement bytes. IMM counts immediate bytes. EMIT holds the descriptor until the consumer takes it. The transitions are as follows:
- PREFIX loops on a prefix byte.
- PREFIX goes to ESCAPE on 0Fh.
- PREFIX or ESCAPE goes on an opcode to ADDR, IMM or EMIT, depending on the opcode table.
- ADDR goes to SIB, DISP, IMM or EMIT.
- SIB goes to DISP, IMM or EMIT.
- DISP and IMM go on to the next field, or to EMIT, when their count runs out.
- EMIT returns to PREFIX when the descriptor is taken.
- Any byte-taking state is forced to EMIT with the error flag when an instruction reaches the length limit before it is complete.

Top module: `instr_field_splitter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A byte is taken on each clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while a descriptor is presented. The descriptor fields stay stable until `out_ready` is seen, and `out_valid` drops in the cycle after that.
- R3: `out_len` equals the number of bytes taken for the instruction: prefixes, escape, opcode, addressing byte, scale-index-base byte, displacement and immediate.
- R4: `out_mod` is bits 7:6 of the addressing byte, the low three bits of `out_reg` are bits 5:3, and the low three bits of `out_rm` are bits 2:0. A scale-index-base byte follows when mod is not 3 and rm is 4. Mod 1 adds one displacement byte, mod 2 adds four, and mod 0 or 3 adds none. Instructions without an addressing byte report mod, reg and rm as 0.
- R5: The one-byte opcode table is as follows. 83h and 80h take an addressing byte and a 1-byte immediate. 85h, 89h, 88h, 8Dh and 31h take an addressing byte only. 7Eh and 75h take a 1-byte immediate. B8h to BFh take an immediate of 2 bytes when the size code is 1, and 4 bytes otherwise. C3h and 90h take nothing more.
- R6: The legacy prefixes are F0h, F2h, F3h, 2Eh, 36h, 3Eh, 26h, 64h, 65h, 66h and 67h. They are accepted in any order and counted in the length. Only 66h changes a decoded field.
- R7: A byte 40h to 4Fh in prefix position is an extension prefix. Its bit 3 is W, bit 2 extends reg to bit 3 of `out_reg`, and bit 0 extends rm to bit 3 of `out_rm`. It takes effect only when the next byte is the opcode or 0Fh. If a legacy prefix follows it, it is ignored. A later extension prefix replaces an earlier one.
- R8: `out_size` is encoded as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. An effective W gives 3, even when 66h is present. Otherwise 66h gives 1. Otherwise the code is 2.
- R9: The byte-only opcodes 88h and 80h report `out_size` 0 whatever prefixes are present.
- R10: An opcode byte that is not in the table gives a descriptor with `out_err` 1 and a length that counts the bytes up to and including that opcode byte. The next byte starts a fresh instruction.
- R11: An instruction whose 15th byte does not complete it gives `out_err` 1 with length 15, and the next byte starts a fresh instruction. An instruction of exactly 15 bytes is not an error.
- R12: After 0Fh the escaped table applies. 84h and 85h take a 4-byte immediate, AFh takes an addressing byte, and any other byte is unsupported. `out_esc` is 1 for such instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte |
| out_valid | output | 1 | Descriptor presented |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_len | output | 4 | Instruction length in bytes |
| out_opcode | output | 8 | Opcode byte |
| out_esc | output | 1 | Opcode came after the 0Fh escape |
| out_mod | output | 2 | Addressing mode field |
| out_reg | output | 4 | Reg field with extension bit |
| out_rm | output | 4 | Rm field with extension bit |
| out_size | output | 2 | Effective operand-size code |
| out_err | output | 1 | Unsupported opcode or length limit reached |

## Verification
The two functions that can fall on the same byte are the length limit and field completion. On the 15th byte, the state machine may be completing a field, or it may be about to move into another one, and the limit check has to override only the second case. This is provoked by sweeping the prefix count so that the last byte of a 3-byte instruction lands on position 15 (no error) and on position 16 (the limit fires on the addressing byte). The trailing immediate byte must then come out as a separate unsupported instruction of length 1. A second overlap, between prefix order and the extension prefix, is judged across every addressing-byte value with the 66h and 4Dh bytes placed in both orders.

// File: rtl/ixd_pkg.sv
package ixd_pkg;

    typedef enum logic [2:0] {
        ST_PFX,
        ST_ESC,
        ST_MODRM,
        ST_SIB,
        ST_DISP,
        ST_IMM,
        ST_EMIT
    } ixd_state_e;

    typedef enum logic [1:0] {
        IMM_NONE,
        IMM_B1,
        IMM_Z,
        IMM_D4
    } imm_kind_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } opsize_e;

    typedef struct packed {
        logic      known;
        logic      has_modrm;
        logic      byte_op;
        imm_kind_e imm;
    } opc_info_t;

endpackage

// File: rtl/ixd_byte_class.sv
module ixd_byte_class (
    input  logic [7:0] byte_in,
    output logic       is_legacy,
    output logic       is_opsz,
    output logic       is_ext,
    output logic       is_escape
);
    always_comb begin
        is_ext    = (byte_in[7:4] == 4'h4);
        is_escape = (byte_in == 8'h0F);
        is_opsz   = (byte_in == 8'h66);
        is_legacy = byte_in inside {8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                                    8'h26, 8'h64, 8'h65, 8'h66, 8'h67};
    end
endmodule

// File: rtl/ixd_opc_table.sv
module ixd_opc_table
    import ixd_pkg::*;
(
    input  logic       esc,
    input  logic [7:0] opc,
    output opc_info_t  info
);
    always_comb begin
        info.known     = 1'b0;
        info.has_modrm = 1'b0;
        info.byte_op   = 1'b0;
        info.imm       = IMM_NONE;
        if (!esc) begin
            case (opc)
                8'h83: begin info.known = 1'b1; info.has_modrm = 1'b1; info.imm = IMM_B1; end
                8'h80: begin info.known = 1'b1; info.has_modrm = 1'b1; info.imm = IMM_B1;
                             info.byte_op = 1'b1; end
                8'h88: begin info.known = 1'b1; info.has_modrm = 1'b1; info.byte_op = 1'b1; end
                8'h85, 8'h89, 8'h8D, 8'h31:
                       begin info.known = 1'b1; info.has_modrm = 1'b1; end
                8'h7E, 8'h75:
                       begin info.known = 1'b1; info.imm = IMM_B1; end
                8'hC3, 8'h90:
                       info.known = 1'b1;
                default: begin
                    if (opc[7:3] == 5'b10111) begin
                        info.known = 1'b1;
                        info.imm   = IMM_Z;
                    end
                end
            endcase
        end else begin
            case (opc)
                8'h84, 8'h85: begin info.known = 1'b1; info.imm = IMM_D4; end
                8'hAF:        begin info.known = 1'b1; info.has_modrm = 1'b1; end
                default:      info.known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ixd_addr_split.sv
module ixd_addr_split #(
    parameter int WIDE_BYTES = 4,
    parameter int CNT_W      = $clog2(WIDE_BYTES + 1)
) (
    input  logic [1:0]       mode,
    input  logic [2:0]       rm,
    output logic             need_sib,
    output logic [CNT_W-1:0] disp_n
);
    always_comb begin
        need_sib = (mode != 2'b11) && (rm == 3'b100);
        case (mode)
            2'b01:   disp_n = CNT_W'(1);
            2'b10:   disp_n = CNT_W'(WIDE_BYTES);
            default: disp_n = '0;
        endcase
    end
endmodule

// File: rtl/instr_field_splitter.sv
module instr_field_splitter
    import ixd_pkg::*;
#(
    parameter int MAX_LEN    = 15,
    parameter int WIDE_BYTES = 4,
    parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LEN_W-1:0] out_len,
    output logic [7:0]       out_opcode,
    output logic             out_esc,
    output logic [1:0]       out_mod,
    output logic [3:0]       out_reg,
    output logic [3:0]       out_rm,
    output logic [1:0]       out_size,
    output logic             out_err
);
    localparam int CNT_W = $clog2(WIDE_BYTES + 1);
    localparam logic [CNT_W-1:0] HALF_BYTES = CNT_W'(WIDE_BYTES / 2);
    localparam logic [CNT_W-1:0] FULL_BYTES = CNT_W'(WIDE_BYTES);

    ixd_state_e       st_q, st_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic [7:0]       opc_q, opc_d, modrm_q, modrm_d;
    logic             esc_q, esc_d, has_mrm_q, has_mrm_d;
    logic [2:0]       ext_q, ext_d;          // {W, R, B}
    logic             ext_live_q, ext_live_d;
    logic             p66_q, p66_d, byteop_q, byteop_d, err_q, err_d;
    logic [CNT_W-1:0] disp_q, disp_d, imm_q, imm_d;

    logic             take, w_eff;
    logic             c_legacy, c_opsz, c_ext, c_esc;
    opc_info_t        info;
    logic             sp_sib;
    logic [CNT_W-1:0] sp_disp, imm_cnt;

    ixd_byte_class u_class (
        .byte_in  (in_byte),
        .is_legacy(c_legacy),
        .is_opsz  (c_opsz),
        .is_ext   (c_ext),
        .is_escape(c_esc)
    );

    ixd_opc_table u_table (
        .esc (st_q == ST_ESC),
        .opc (in_byte),
        .info(info)
    );

    ixd_addr_split #(.WIDE_BYTES(WIDE_BYTES), .CNT_W(CNT_W)) u_split (
        .mode    (in_byte[7:6]),
        .rm      (in_byte[2:0]),
        .need_sib(sp_sib),
        .disp_n  (sp_disp)
    );

    assign take  = in_valid && in_ready;
    assign w_eff = ext_live_q && ext_q[2];

    always_comb begin
        case (info.imm)
            IMM_B1:  imm_cnt = CNT_W'(1);
            IMM_Z:   imm_cnt = (p66_q && !w_eff) ? HALF_BYTES : FULL_BYTES;
            IMM_D4:  imm_cnt = FULL_BYTES;
            default: imm_cnt = '0;
        endcase
    end

    // next-state and datapath update
    always_comb begin
        st_d       = st_q;
        len_d      = len_q;
        opc_d      = opc_q;
        modrm_d    = modrm_q;
        esc_d      = esc_q;
        has_mrm_d  = has_mrm_q;
        ext_d      = ext_q;
        ext_live_d = ext_live_q;
        p66_d      = p66_q;
        byteop_d   = byteop_q;
        err_d      = err_q;
        disp_d     = disp_q;
        imm_d      = imm_q;
        unique case (st_q)
            ST_PFX, ST_ESC: begin
                if (take) begin
                    if (st_q == ST_PFX && c_ext) begin
                        ext_d      = {in_byte[3], in_byte[2], in_byte[0]};
                        ext_live_d = 1'b1;
                    end else if (st_q == ST_PFX && c_legacy) begin
                        ext_live_d = 1'b0;
                        if (c_opsz) p66_d = 1'b1;
                    end else if (st_q == ST_PFX && c_esc) begin
                        esc_d = 1'b1;
                        st_d  = ST_ESC;
                    end else begin
                        opc_d = in_byte;
                        if (!info.known) begin
                            err_d = 1'b1;
                            st_d  = ST_EMIT;
                        end else begin
                            byteop_d = info.byte_op;
                            imm_d    = imm_cnt;
                            if (info.has_modrm)    st_d = ST_MODRM;
                            else if (imm_cnt != 0) st_d = ST_IMM;
                            else                   st_d = ST_EMIT;
                        end
                    end
                end
            end
            ST_MODRM: begin
                if (take) begin
                    modrm_d   = in_byte;
                    has_mrm_d = 1'b1;
                    disp_d    = sp_disp;
                    if (sp_sib)            st_d = ST_SIB;
                    else if (sp_disp != 0) st_d = ST_DISP;
                    else if (imm_q != 0)   st_d = ST_IMM;
                    else                   st_d = ST_EMIT;
                end
            end
            ST_SIB: begin
                if (take) begin
                    if (disp_q != 0)     st_d = ST_DISP;
                    else if (imm_q != 0) st_d = ST_IMM;
                    else                 st_d = ST_EMIT;
                end
            end
            ST_DISP: begin
                if (take) begin
                    disp_d = disp_q - 1'b1;
                    if (disp_q == CNT_W'(1)) st_d = (imm_q != 0) ? ST_IMM : ST_EMIT;
                end
            end
            ST_IMM: begin
                if (take) begin
                    imm_d = imm_q - 1'b1;
                    if (imm_q == CNT_W'(1)) st_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    st_d       = ST_PFX;
                    len_d      = '0;
                    opc_d      = '0;
                    modrm_d    = '0;
                    esc_d      = 1'b0;
                    has_mrm_d  = 1'b0;
                    ext_d      = '0;
                    ext_live_d = 1'b0;
                    p66_d      = 1'b0;
                    byteop_d   = 1'b0;
                    err_d      = 1'b0;
                    disp_d     = '0;
                    imm_d      = '0;
                end
            end
            default: st_d = ST_PFX;
        endcase
        if (take) begin
            len_d = len_q + 1'b1;
            if (st_d != ST_EMIT && len_q == LEN_W'(MAX_LEN - 1)) begin
                st_d  = ST_EMIT;
                err_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_PFX;
            len_q      <= '0;
            opc_q      <= '0;
            modrm_q    <= '0;
            esc_q      <= 1'b0;
            has_mrm_q  <= 1'b0;
            ext_q      <= '0;
            ext_live_q <= 1'b0;
            p66_q      <= 1'b0;
            byteop_q   <= 1'b0;
            err_q      <= 1'b0;
            disp_q     <= '0;
            imm_q      <= '0;
        end else begin
            st_q       <= st_d;
            len_q      <= len_d;
            opc_q      <= opc_d;
            modrm_q    <= modrm_d;
            esc_q      <= esc_d;
            has_mrm_q  <= has_mrm_d;
            ext_q      <= ext_d;
            ext_live_q <= ext_live_d;
            p66_q      <= p66_d;
            byteop_q   <= byteop_d;
            err_q      <= err_d;
            disp_q     <= disp_d;
            imm_q      <= imm_d;
        end
    end

    // descriptor outputs
    always_comb begin
        in_ready   = (st_q != ST_EMIT);
        out_valid  = (st_q == ST_EMIT);
        out_len    = len_q;
        out_opcode = opc_q;
        out_esc    = esc_q;
        out_err    = err_q;
        out_mod    = has_mrm_q ? modrm_q[7:6] : 2'b00;
        out_reg    = has_mrm_q ? {ext_live_q && ext_q[1], modrm_q[5:3]} : 4'h0;
        out_rm     = has_mrm_q ? {ext_live_q && ext_q[0], modrm_q[2:0]} : 4'h0;
        if (byteop_q)   out_size = SZ_8;
        else if (w_eff) out_size = SZ_64;
        else if (p66_q) out_size = SZ_16;
        else            out_size = SZ_32;
    end

endmodule

// File: rtl/ixd_chk.sv
module ixd_chk #(
    parameter int MAX_LEN = 15,
    parameter int LEN_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [LEN_W-1:0] out_len,
    input logic [7:0]       out_opcode,
    input logic [1:0]       out_mod,
    input logic             out_err
);
    logic [LEN_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      seen_q <= '0;
        else if (out_valid && out_ready) seen_q <= '0;
        else if (in_valid && in_ready)   seen_q <= seen_q + 1'b1;
    end

    // R2
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_opcode) && $stable(out_err));

    // R2
    emit_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));

    // R3
    len_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len == seen_q);

    // R11
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(MAX_LEN)));

    // R4
    wide_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_err && out_mod == 2'b10 |-> out_len >= LEN_W'(6));

endmodule

bind instr_field_splitter ixd_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_len   (out_len),
    .out_opcode(out_opcode),
    .out_mod   (out_mod),
    .out_err   (out_err)
);

// File: tb/instr_field_splitter_test.sv
module instr_field_splitter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, out_valid;
    logic       out_ready = 1'b0;
    logic [3:0] out_len, out_reg, out_rm;
    logic [7:0] out_opcode;
    logic       out_esc, out_err;
    logic [1:0] out_mod, out_size;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    instr_field_splitter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_len(out_len), .out_opcode(out_opcode), .out_esc(out_esc),
        .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm),
        .out_size(out_size), .out_err(out_err)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        in_byte  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic push_n(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) push(b);
    endtask

    task automatic collect(input string tag, input int e_len, input int e_opc, input bit e_esc,
                           input int e_mod, input int e_reg, input int e_rm, input int e_size,
                           input bit e_err);
        bit ok;
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        n_chk++;
        if (e_err)
            ok = out_err && (out_len == e_len);
        else
            ok = !out_err && out_len == e_len && out_opcode == e_opc && out_esc == e_esc &&
                 out_mod == e_mod && out_reg == e_reg && out_rm == e_rm && out_size == e_size;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual len=%0d opc=%h esc=%0d mod=%0d reg=%0d rm=%0d size=%0d err=%0d expected len=%0d opc=%h esc=%0d mod=%0d reg=%0d rm=%0d size=%0d err=%0d",
                     tag, out_len, out_opcode, out_esc, out_mod, out_reg, out_rm, out_size, out_err,
                     e_len, e_opc[7:0], e_esc, e_mod, e_reg, e_rm, e_size, e_err);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid after reset", out_valid == 1'b0, out_valid, 0);
        chk("R1 in_ready after reset", in_ready == 1'b1, in_ready, 1);

        // R5 short jump and immediate forms
        push(8'h7E); push(8'h16);
        collect("R5 short jump", 2, 'h7E, 0, 0, 0, 0, 2, 0);
        push(8'hB8); push_n(8'h01, 4);
        collect("R5 mov imm32", 5, 'hB8, 0, 0, 0, 0, 2, 0);
        // R8 size override and W
        push(8'h66); push(8'hBB); push_n(8'h02, 2);
        collect("R8 66h gives 16-bit imm", 4, 'hBB, 0, 0, 0, 0, 1, 0);
        push(8'h48); push(8'hB8); push_n(8'h03, 4);
        collect("R8 W gives 64-bit", 6, 'hB8, 0, 0, 0, 0, 3, 0);

        // R12 escaped opcodes
        push(8'h0F); push(8'h84); push_n(8'h44, 4);
        collect("R12 escaped rel32", 6, 'h84, 1, 0, 0, 0, 2, 0);
        push(8'h0F); push(8'hAF); push(8'hC1);
        collect("R12 escaped with addressing", 3, 'hAF, 1, 3, 0, 1, 2, 0);

        // R9 byte-only operations
        push(8'h66); push(8'h88); push(8'hC3);
        collect("R9 byte op ignores 66h", 3, 'h88, 0, 3, 0, 3, 0, 0);
        push(8'h48); push(8'h80); push(8'hE8); push(8'h01);
        collect("R9 byte op ignores W", 4, 'h80, 0, 3, 5, 0, 0, 0);

        // R7 second extension prefix replaces first
        push(8'h41); push(8'h44); push(8'h89); push(8'hC8);
        collect("R7 later extension wins", 4, 'h89, 0, 3, 9, 0, 2, 0);
        // R7 mandatory prefix before extension, extension before escape
        push(8'hF3); push(8'h48); push(8'h0F); push(8'hAF); push(8'hC0);
        collect("R7 extension before escape", 5, 'hAF, 1, 3, 0, 0, 3, 0);

        // R6 legacy prefixes in mixed order
        push(8'hF0); push(8'hF2); push(8'h2E); push(8'h65); push(8'h67); push(8'h85); push(8'hC0);
        collect("R6 mixed legacy prefixes", 7, 'h85, 0, 3, 0, 0, 2, 0);

        // R10 unsupported opcodes and resync
        push(8'h62);
        collect("R10 unsupported opcode", 1, 0, 0, 0, 0, 0, 0, 1);
        push(8'h90);
        collect("R10 resync after error", 1, 'h90, 0, 0, 0, 0, 2, 0);
        push(8'h66); push(8'h62);
        collect("R10 unsupported after prefix", 2, 0, 0, 0, 0, 0, 0, 1);
        push(8'h0F); push(8'h0B);
        collect("R10 R12 unsupported escaped", 2, 0, 0, 0, 0, 0, 0, 1);

        // R11 length limit
        push_n(8'h66, 15);
        collect("R11 fifteen prefixes", 15, 0, 0, 0, 0, 0, 0, 1);
        push(8'hC3);
        collect("R11 resync after limit", 1, 'hC3, 0, 0, 0, 0, 2, 0);
        push_n(8'h66, 12); push(8'h83); push(8'hC0); push(8'h01);
        collect("R11 exactly fifteen bytes", 15, 'h83, 0, 3, 0, 0, 1, 0);
        push_n(8'h66, 13); push(8'h83); push(8'hC0);
        collect("R11 limit on addressing byte", 15, 0, 0, 0, 0, 0, 0, 1);
        push(8'h01);
        collect("R11 leftover byte starts fresh", 1, 0, 0, 0, 0, 0, 0, 1);

        // R2 descriptor hold with stalled consumer and offered byte
        push(8'h83); push(8'h45); push(8'h08); push(8'h01);
        in_byte  = 8'h90;
        in_valid = 1'b1;
        while (!out_valid) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk("R2 descriptor held", out_valid && !in_ready && out_len == 4, out_len, 4);
            @(negedge clk);
        end
        collect("R2 R4 held descriptor", 4, 'h83, 0, 1, 0, 5, 2, 0);
        chk("R2 valid drops after take", out_valid == 1'b0, out_valid, 0);
        push(8'h90);
        collect("R2 offered byte not consumed early", 1, 'h90, 0, 0, 0, 0, 2, 0);

        // R3 R4 R7 R8 sweep over every addressing byte and prefix placement
        for (int p = 0; p < 5; p++) begin
            for (int m = 0; m < 256; m++) begin
                int  md, rmv, rg, sib, dn, npfx, e_len, e_reg, e_rm, e_size;
                bit  w_live, rb_live, p66;
                md  = m / 64;
                rg  = (m / 8) % 8;
                rmv = m % 8;
                sib = (md != 3 && rmv == 4) ? 1 : 0;
                dn  = (md == 1) ? 1 : (md == 2) ? 4 : 0;
                case (p)
                    1:       begin push(8'h66); npfx = 1; w_live = 0; rb_live = 0; p66 = 1; end
                    2:       begin push(8'h4D); npfx = 1; w_live = 1; rb_live = 1; p66 = 0; end
                    3:       begin push(8'h4D); push(8'h66); npfx = 2; w_live = 0; rb_live = 0; p66 = 1; end
                    4:       begin push(8'h66); push(8'h4D); npfx = 2; w_live = 1; rb_live = 1; p66 = 1; end
                    default: begin npfx = 0; w_live = 0; rb_live = 0; p66 = 0; end
                endcase
                push(8'h83);
                push(m[7:0]);
                if (sib == 1) push(8'h24);
                push_n(8'h66, dn);
                push(8'h0F);
                e_len  = npfx + 3 + sib + dn;
                e_reg  = rg + (rb_live ? 8 : 0);
                e_rm   = rmv + (rb_live ? 8 : 0);
                e_size = w_live ? 3 : (p66 ? 1 : 2);
                collect("R3 R4 R7 R8 sweep", e_len, 'h83, 0, md, e_reg, e_rm, e_size, 0);
            end
        end

        finish_run();
    end
endmodule